// File: doc/BRIEF.md
# MSI Doorbell Interrupt Controller

This block collects message-signalled interrupts from endpoints and presents them to the host as one level-sensitive interrupt line. An endpoint raises a vector by writing its number to a doorbell register. The controller records that event as a pending bit. Software then finds out which vectors fired by reading the banked status words. It acknowledges a vector by writing a one to its status bit, and it masks or unmasks vectors through banked enable words.

All registers share one simple word-addressed register port that has separate read and write strobes. Reads return data one cycle after the request. Doorbell writes pass through a one-entry staging register before they reach the pending bits. The number of vectors is a parameter and must be a multiple of 32 and no more than 256.

Top module: `msi_doorbell_ctrl`

## Requirements
- R1: After a synchronous reset, every pending bit and every enable bit is zero, `irq` is low and `bus_rdata` is zero.
- R2: A write to word address 0x1F (byte 0x7C) marks vector (data mod NUM_VEC) pending on the clock edge after the write. The vector's enable bit does not affect this, and clearing the enable bit later leaves the pending bit set.
- R3: Vector n is bit (n mod 32) of the status word at word address 0x20 + n/32 (byte 0x80 + (n/32)*4). A read issued in one cycle presents its word on `bus_rdata` after that cycle's clock edge.
- R4: Writing a status word clears each pending bit whose data bit is 1. Pending bits whose data bit is 0 are left unchanged.
- R5: The enable words at word address 0x28 + k (byte 0xA0 + k*4) are plain read/write registers, with vector n at bit (n mod 32) of word n/32.
- R6: `irq` is a register that goes high one cycle after any vector has both its pending bit and its enable bit set. It goes low one cycle after no such vector remains.
- R7: When a staged doorbell set and a clearing write hit the same pending bit on the same edge, the bit ends up set. Other bits cleared by that write are still cleared.
- R8: Reads of undefined word addresses, including the write-only doorbell address, return zero. Writes to undefined addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Word address (byte offset / 4) |
| bus_wen | input | 1 | Write strobe |
| bus_ren | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq | output | 1 | Aggregated interrupt to the host |

## Verification
The doorbell path and the acknowledge path can reach the same status bit on the same edge. This happens because the staged doorbell lands one cycle after its write, so a clearing write in the next bus cycle meets it. The bench provokes this case by issuing a doorbell for one vector and, in the very next cycle, a clearing write that covers that vector and another vector that is already pending. The result is judged by reading the status word back: the new vector's bit must remain set and the older vector's bit must be cleared.

// File: rtl/msi_pkg.sv
package msi_pkg;

    localparam int WORD_W      = 32;
    localparam int ADDR_W      = 6;
    localparam int SLOT_W      = 3;
    localparam int BANK_SLOTS  = 1 << SLOT_W;

    localparam logic [ADDR_W-1:0] DOORBELL_WADDR = 6'h1F;
    localparam logic [ADDR_W-1:0] STATUS_WBASE   = 6'h20;
    localparam logic [ADDR_W-1:0] ENABLE_WBASE   = 6'h28;

    typedef enum logic [1:0] {
        RK_NONE,
        RK_DOORBELL,
        RK_STATUS,
        RK_ENABLE
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e         kind;
        logic [SLOT_W-1:0] slot;
    } reg_sel_t;

    function automatic logic [WORD_W-1:0] bit_onehot(input logic [4:0] pos);
        return WORD_W'(1) << pos;
    endfunction

endpackage

// File: rtl/msi_reg_decode.sv
module msi_reg_decode
    import msi_pkg::*;
#(
    parameter int NUM_WORDS = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel
);
    localparam int HI_W = ADDR_W - SLOT_W;

    logic [HI_W-1:0]   hi;
    logic [SLOT_W-1:0] lo;
    logic              slot_ok;

    assign hi      = addr[ADDR_W-1:SLOT_W];
    assign lo      = addr[SLOT_W-1:0];
    assign slot_ok = (32'(lo) < NUM_WORDS);

    always_comb begin
        sel.slot = lo;
        sel.kind = RK_NONE;
        if (addr == DOORBELL_WADDR)
            sel.kind = RK_DOORBELL;
        else if (hi == STATUS_WBASE[ADDR_W-1:SLOT_W] && slot_ok)
            sel.kind = RK_STATUS;
        else if (hi == ENABLE_WBASE[ADDR_W-1:SLOT_W] && slot_ok)
            sel.kind = RK_ENABLE;
    end
endmodule

// File: rtl/msi_doorbell_stage.sv
module msi_doorbell_stage
    import msi_pkg::*;
#(
    parameter int NUM_VEC = 256,
    localparam int VEC_W  = $clog2(NUM_VEC)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ring,
    input  logic [WORD_W-1:0] ring_data,
    output logic              stg_valid,
    output logic [VEC_W-1:0]  stg_vec
);
    logic [WORD_W-1:0] wrapped;

    assign wrapped = ring_data % WORD_W'(NUM_VEC);

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_valid <= 1'b0;
            stg_vec   <= '0;
        end else begin
            stg_valid <= ring;
            if (ring)
                stg_vec <= wrapped[VEC_W-1:0];
        end
    end
endmodule

// File: rtl/msi_vec_word.sv
module msi_vec_word
    import msi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] set_mask,
    input  logic [WORD_W-1:0] clr_mask,
    input  logic              en_we,
    input  logic [WORD_W-1:0] en_wdata,
    output logic [WORD_W-1:0] pend,
    output logic [WORD_W-1:0] enab,
    output logic              hit
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
            enab <= '0;
        end else begin
            pend <= (pend & ~clr_mask) | set_mask;
            if (en_we)
                enab <= en_wdata;
        end
    end

    assign hit = |(pend & enab);

    // R4: acknowledged bits without a concurrent set are cleared
    p_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (clr_mask != '0) |=> ((pend & $past(clr_mask & ~set_mask)) == '0));

    // R4: with no set and no clear the pending word holds
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (clr_mask == '0 && set_mask == '0) |=> $stable(pend));

    // R7: set beats clear on a collision
    p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
        ((set_mask & clr_mask) != '0) |=>
            ((pend & $past(set_mask & clr_mask)) == $past(set_mask & clr_mask)));

    // R5: enable word takes the written value
    p_enable_write_r5: assert property (@(posedge clk) disable iff (rst)
        en_we |=> (enab == $past(en_wdata)));
endmodule

// File: rtl/msi_doorbell_ctrl.sv
module msi_doorbell_ctrl
    import msi_pkg::*;
#(
    parameter int NUM_VEC = 256,
    localparam int NUM_WORDS = NUM_VEC / WORD_W,
    localparam int VEC_W     = $clog2(NUM_VEC)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wen,
    input  logic              bus_ren,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              irq
);
    reg_sel_t             sel;
    logic                 stg_valid;
    logic [VEC_W-1:0]     stg_vec;
    logic [WORD_W-1:0]    pend_w [NUM_WORDS];
    logic [WORD_W-1:0]    enab_w [NUM_WORDS];
    logic [NUM_WORDS-1:0] hit_w;
    logic [NUM_VEC-1:0]   pend_flat;
    logic [NUM_VEC-1:0]   enab_flat;
    logic [WORD_W-1:0]    rd_word;
    logic                 irq_q;

    msi_reg_decode #(.NUM_WORDS(NUM_WORDS)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    msi_doorbell_stage #(.NUM_VEC(NUM_VEC)) u_stage (
        .clk       (clk),
        .rst       (rst),
        .ring      (bus_wen && sel.kind == RK_DOORBELL),
        .ring_data (bus_wdata),
        .stg_valid (stg_valid),
        .stg_vec   (stg_vec)
    );

    for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
        logic              hit_here;
        logic [WORD_W-1:0] set_m;
        logic [WORD_W-1:0] clr_m;
        logic              en_we;

        assign hit_here = stg_valid && ((32'(stg_vec) >> 5) == k);
        assign set_m    = hit_here ? bit_onehot(stg_vec[4:0]) : '0;
        assign clr_m    = (bus_wen && sel.kind == RK_STATUS && 32'(sel.slot) == k)
                          ? bus_wdata : '0;
        assign en_we    = bus_wen && sel.kind == RK_ENABLE && 32'(sel.slot) == k;

        msi_vec_word u_word (
            .clk      (clk),
            .rst      (rst),
            .set_mask (set_m),
            .clr_mask (clr_m),
            .en_we    (en_we),
            .en_wdata (bus_wdata),
            .pend     (pend_w[k]),
            .enab     (enab_w[k]),
            .hit      (hit_w[k])
        );

        assign pend_flat[k*WORD_W +: WORD_W] = pend_w[k];
        assign enab_flat[k*WORD_W +: WORD_W] = enab_w[k];
    end

    always_comb begin
        rd_word = '0;
        for (int k = 0; k < NUM_WORDS; k++) begin
            if (32'(sel.slot) == k) begin
                if (sel.kind == RK_STATUS) rd_word = pend_w[k];
                if (sel.kind == RK_ENABLE) rd_word = enab_w[k];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
            irq_q     <= 1'b0;
        end else begin
            if (bus_ren)
                bus_rdata <= rd_word;
            irq_q <= |hit_w;
        end
    end

    assign irq = irq_q;

    // R2: a staged doorbell always lands in the pending bank
    p_doorbell_lands_r2: assert property (@(posedge clk) disable iff (rst)
        stg_valid |=> pend_flat[$past(stg_vec)]);

    // R6: with every vector masked the interrupt falls
    p_irq_masked_r6: assert property (@(posedge clk) disable iff (rst)
        (enab_flat == '0) |=> !irq);

    // R6: no pending vector means no interrupt next cycle
    p_irq_idle_r6: assert property (@(posedge clk) disable iff (rst)
        (pend_flat == '0) |=> !irq);

    // R8: undefined addresses read back zero
    p_undef_read_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_ren && (sel.kind == RK_NONE || sel.kind == RK_DOORBELL)) |=> (bus_rdata == '0));
endmodule

// File: tb/msi_doorbell_ctrl_tb.sv
module msi_doorbell_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  bus_addr = '0;
    logic        bus_wen = 1'b0;
    logic        bus_ren = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;
    logic rd_seen = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    localparam logic [5:0] DB = 6'h1F;
    localparam logic [5:0] ST = 6'h20;
    localparam logic [5:0] EN = 6'h28;

    always #2 clk = ~clk;

    msi_doorbell_ctrl u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wen(bus_wen),
        .bus_ren(bus_ren), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always @(posedge clk) rd_seen <= rst ? 1'b0 : bus_ren;

    // monitor: pops expected read data as responses appear
    always @(negedge clk) begin
        if (rd_seen) begin
            n_checks++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL scoreboard: unexpected read, actual %h expected none", bus_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    n_fail++;
                    $display("FAIL %s: rdata actual %h expected %h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
        @(negedge clk);
        bus_wen = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, input logic [31:0] e, input string t);
        bus_addr = a; bus_ren = 1'b1;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        bus_ren = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_irq(input logic e, input string t);
        n_checks++;
        if (irq !== e) begin
            n_fail++;
            $display("FAIL %s: irq actual %b expected %b", t, irq, e);
        end
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk_irq(1'b0, "R1");
        n_checks++;
        if (bus_rdata !== 32'h0) begin
            n_fail++;
            $display("FAIL R1: rdata actual %h expected 0", bus_rdata);
        end
        rd(ST, 32'h0, "R1");
        rd(EN + 6'd0, 32'h0, "R1");
        rd(EN + 6'd7, 32'h0, "R1");

        // R5 enable read/write
        wr(EN + 6'd2, 32'hDEADBEEF);
        rd(EN + 6'd2, 32'hDEADBEEF, "R5");
        wr(EN + 6'd2, 32'h0);
        rd(EN + 6'd2, 32'h0, "R5");

        // R2/R3 doorbell while masked
        wr(DB, 32'd37);
        idle(2);
        rd(ST + 6'd1, 32'h20, "R3");
        chk_irq(1'b0, "R6");
        wr(DB, 32'd259);
        idle(1);
        rd(ST, 32'h8, "R2");

        // R6 unmask raises the interrupt
        wr(EN + 6'd1, 32'h20);
        idle(2);
        chk_irq(1'b1, "R6");

        // R4 write of zeros then ones
        wr(ST + 6'd1, 32'h0);
        rd(ST + 6'd1, 32'h20, "R4");
        wr(ST + 6'd1, 32'h20);
        rd(ST + 6'd1, 32'h0, "R4");
        idle(1);
        chk_irq(1'b0, "R6");

        // R3 top vector
        wr(DB, 32'd255);
        idle(1);
        rd(ST + 6'd7, 32'h80000000, "R3");
        wr(ST, 32'hFFFFFFFF);
        wr(ST + 6'd7, 32'hFFFFFFFF);
        rd(ST, 32'h0, "R4");
        rd(ST + 6'd7, 32'h0, "R4");

        // R7 doorbell set collides with acknowledge
        wr(DB, 32'd7);
        idle(1);
        wr(DB, 32'd5);
        wr(ST, 32'hA0);
        idle(1);
        rd(ST, 32'h20, "R7");

        // R8 undefined addresses
        wr(6'h00, 32'hFFFFFFFF);
        wr(6'h30, 32'hFFFFFFFF);
        wr(6'h3F, 32'hFFFFFFFF);
        rd(6'h00, 32'h0, "R8");
        rd(DB, 32'h0, "R8");
        rd(6'h30, 32'h0, "R8");
        rd(EN + 6'd0, 32'h0, "R8");
        rd(ST, 32'h20, "R8");

        // R6/R2 mask gates irq but keeps pending
        wr(ST, 32'hFFFFFFFF);
        wr(EN + 6'd7, 32'h80000000);
        wr(DB, 32'd255);
        idle(2);
        chk_irq(1'b1, "R6");
        wr(EN + 6'd7, 32'h0);
        idle(1);
        chk_irq(1'b0, "R6");
        rd(ST + 6'd7, 32'h80000000, "R2");

        idle(3);
        n_checks++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard: pending actual %0d expected 0", exp_q.size());
        end
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule